// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a byte-wide serial EEPROM on a two-wire bus. Both bus lines are brought into the system clock domain and edge-detected there. The block finds bus start and stop conditions and checks the device-select byte against two strap pins. It then takes a two-byte word address and either stores incoming data bytes or returns stored bytes to the bus master. The data line is driven open-drain: the block only ever pulls it low, through an output-enable pin.

Write data goes into an internal byte array. Incoming bytes advance only the in-page part of the word address, so a long burst wraps inside one page. A stop condition that ends a write starts a self-timed programming period, modelled as a count of clock cycles. During that period the block stays off the bus. A master can therefore poll with the device-select byte until it is acknowledged again. When the protect pin is high, bytes are still acknowledged but the array is left unchanged.

Top module: `twi_ee_slave`

## Requirements
- R1: With SCL high, a falling SDA is a start and a rising SDA is a stop. A start, when not busy, always begins reception of a device-select byte. A stop that follows no data byte returns the block to standby, ready at once for a new start.
- R2: The device-select byte is, from MSB down, 1,0,1,0, then a 0, then two bits equal to the strap pins (bit 2 = strap[1], bit 1 = strap[0]), then the direction bit in bit 0 (1 = read, 0 = write). On a match the block pulls SDA low through the whole ninth SCL pulse.
- R3: On any other select byte the block gives no acknowledge and leaves SDA released until the next start.
- R4: A write sends a high address byte, a low address byte, then data bytes. Each byte is acknowledged on its ninth pulse, and each data byte is stored at the current word address.
- R5: After each stored byte only the low PAGE_W address bits increment. Past the page end they wrap to the page start, so extra bytes overwrite earlier ones in that page.
- R6: A stop after at least one data byte starts a busy period of BUSY_CYCLES clocks. During it the block ignores the bus and acknowledges nothing, including its own select byte. Afterwards it acknowledges again.
- R7: With the protect pin high, every byte of a write is acknowledged and the busy period still runs, but the array keeps its old contents.
- R8: A read returns the byte at the current word address, MSB first. Each bit changes only after an SCL fall. The address increments by one after each byte; a master acknowledge continues the read and a master not-acknowledge ends it. A read select with no address phase starts at the address following the last one accessed.
- R9: A random read is a write select plus two address bytes, then a repeated start and a read select. It returns data from the address just sent.
- R10: The SDA enable changes only in the cycle after a detected SCL fall, so SDA never moves while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Device-select strap pins |
| wp_i | input | 1 | Write protect, high blocks array updates |

## Verification
The bench builds the block with a 64-byte array, 8-byte pages and a 300-cycle busy period. With 8-byte pages, a ten-byte burst crosses the page end and wraps twice over earlier bytes, so the overwrite order can be checked in a single read. With 300 cycles, the first poll after a write falls inside the busy period and a later poll falls after it, so both the silent phase and the return of the acknowledge are observed. With the straps set to 2'b10, one select byte with a wrong strap value and one with a wrong fixed code are both rejected.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT,
        ST_BUSY
    } ee_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam logic [4:0] SEL_CODE = 5'b1010_0;

    function automatic logic sel_hit(input logic [7:0] b, input logic [1:0] strap);
        return (b[7:3] == SEL_CODE) && (b[2:1] == strap);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_ee_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     sda_lvl
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_prev, sda_prev, scl_lvl;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_ff[0] <= 1'b1;
                        sda_ff[0] <= 1'b1;
                    end else begin
                        scl_ff[0] <= scl_i;
                        sda_ff[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_ff[g] <= 1'b1;
                        sda_ff[g] <= 1'b1;
                    end else begin
                        scl_ff[g] <= scl_ff[g-1];
                        sda_ff[g] <= sda_ff[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    always_comb begin
        evt.rise  = scl_lvl & ~scl_prev;
        evt.fall  = ~scl_lvl & scl_prev;
        evt.start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        evt.stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/twi_store.sv
module twi_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave
    import twi_ee_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int MEM_AW      = 8,
    parameter int PAGE_W      = 6,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    localparam int HI_W = ADDR_W - 8;
    localparam int CW   = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_CYCLES - 1);
    localparam logic [3:0] BYTE_END = 4'd8;
    localparam logic [3:0] ACK_END  = 4'd9;

    bus_evt_t        evt;
    logic            sda_lvl;
    ee_state_e       state, nxt_st;
    logic [7:0]      shreg, rd_byte;
    logic [3:0]      bitcnt;
    logic            sda_drv, wr_pend, mack;
    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]   busy_cnt;
    logic            mem_we, is_busy, is_idle;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .evt(evt), .sda_lvl(sda_lvl)
    );

    assign mem_we = evt.fall && (state == ST_WDAT) && (bitcnt == BYTE_END) && !wp_i;

    twi_store #(.AW(MEM_AW), .DW(8)) u_store (
        .clk(clk), .we(mem_we),
        .waddr(addr_q[MEM_AW-1:0]), .wdata(shreg),
        .raddr(addr_q[MEM_AW-1:0]), .rdata(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nxt_st   <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            sda_drv  <= 1'b0;
            wr_pend  <= 1'b0;
            mack     <= 1'b0;
            addr_q   <= '0;
            busy_cnt <= '0;
        end else if (state == ST_BUSY) begin
            sda_drv <= 1'b0;
            if (busy_cnt == BUSY_LAST) begin
                state    <= ST_IDLE;
                busy_cnt <= '0;
            end else begin
                busy_cnt <= busy_cnt + 1'b1;
            end
        end else if (evt.start) begin
            state   <= ST_DEV;
            bitcnt  <= '0;
            sda_drv <= 1'b0;
            wr_pend <= 1'b0;
        end else if (evt.stop) begin
            sda_drv <= 1'b0;
            bitcnt  <= '0;
            wr_pend <= 1'b0;
            state   <= wr_pend ? ST_BUSY : ST_IDLE;
            busy_cnt <= '0;
        end else if (state == ST_RDAT) begin
            if (evt.rise) begin
                if (bitcnt == BYTE_END) mack <= ~sda_lvl;
                bitcnt <= bitcnt + 4'd1;
            end else if (evt.fall) begin
                if (bitcnt == ACK_END) begin
                    bitcnt <= '0;
                    if (mack) begin
                        shreg   <= rd_byte;
                        sda_drv <= ~rd_byte[7];
                        addr_q  <= addr_q + 1'b1;
                    end else begin
                        state   <= ST_IDLE;
                        sda_drv <= 1'b0;
                    end
                end else if (bitcnt == BYTE_END) begin
                    sda_drv <= 1'b0;
                end else if (bitcnt != 4'd0) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    sda_drv <= ~shreg[6];
                end
            end
        end else if (state != ST_IDLE) begin
            if (evt.rise) begin
                if (bitcnt < BYTE_END) shreg <= {shreg[6:0], sda_lvl};
                bitcnt <= bitcnt + 4'd1;
            end else if (evt.fall) begin
                if (bitcnt == BYTE_END) begin
                    case (state)
                        ST_DEV: begin
                            if (sel_hit(shreg, strap_i)) begin
                                sda_drv <= 1'b1;
                                nxt_st  <= shreg[0] ? ST_RDAT : ST_AHI;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            addr_q  <= {shreg[HI_W-1:0], addr_q[7:0]};
                            sda_drv <= 1'b1;
                            nxt_st  <= ST_ALO;
                        end
                        ST_ALO: begin
                            addr_q[7:0] <= shreg;
                            sda_drv     <= 1'b1;
                            nxt_st      <= ST_WDAT;
                        end
                        default: begin
                            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                            wr_pend <= 1'b1;
                            sda_drv <= 1'b1;
                            nxt_st  <= ST_WDAT;
                        end
                    endcase
                end else if (bitcnt == ACK_END) begin
                    bitcnt <= '0;
                    state  <= nxt_st;
                    if (nxt_st == ST_RDAT) begin
                        shreg   <= rd_byte;
                        sda_drv <= ~rd_byte[7];
                        addr_q  <= addr_q + 1'b1;
                    end else begin
                        sda_drv <= 1'b0;
                    end
                end
            end
        end
    end

    assign sda_oe  = sda_drv;
    assign is_busy = (state == ST_BUSY);
    assign is_idle = (state == ST_IDLE);

endmodule

// File: rtl/twi_ee_checker.sv
module twi_ee_checker #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_fall,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic              mem_we,
    input logic              is_busy,
    input logic              is_idle,
    input logic [ADDR_W-1:0] addr_q
);
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall)); // R10

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_busy |-> !sda_oe); // R6

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(is_busy) |-> $past(stop_evt)); // R6

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sda_oe); // R4

    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(addr_q[ADDR_W-1:PAGE_W])); // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        is_idle |-> !sda_oe); // R3

endmodule

bind twi_ee_slave twi_ee_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .scl_fall(evt.fall), .stop_evt(evt.stop),
    .sda_oe(sda_oe), .mem_we(mem_we), .is_busy(is_busy),
    .is_idle(is_idle), .addr_q(addr_q)
);

// File: tb/tb_twi_ee_slave.sv
module tb_twi_ee_slave;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int tests = 0, fails = 0, unstable = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twi_ee_slave #(.ADDR_W(15), .MEM_AW(6), .PAGE_W(3), .BUSY_CYCLES(300), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(2'b10), .wp_i(wp)
    );

    localparam logic [7:0] SEL_W = 8'hA4, SEL_R = 8'hA5;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
        end
        m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
        ack = !sda_line;
        qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic s1, s2;
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qwait(); m_scl = 1'b1; qwait(); s1 = sda_line; qwait(); s2 = sda_line;
            if (s1 != s2) unstable++;
            b = {b[6:0], s1};
            m_scl = 1'b0;
        end
        qwait(); m_sda = !give_ack; qwait(); m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait(); m_sda = 1'b1;
    endtask

    task automatic write_burst(input logic [14:0] a, input int n, input logic [7:0] first);
        bit ack;
        bus_start();
        send_byte(SEL_W, ack); check(ack, "R2 select ack", ack, 1);
        send_byte({1'b0, a[14:8]}, ack); check(ack, "R4 addr hi ack", ack, 1);
        send_byte(a[7:0], ack); check(ack, "R4 addr lo ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(first + 8'(i), ack);
            check(ack, "R4 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        bit ack;
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 40) begin
            bus_start(); send_byte(SEL_W, ack); bus_stop();
            if (!ack) polls++;
        end
        check(ack, "R6 ack after busy", ack, 1);
    endtask

    task automatic rand_read_check(input logic [14:0] a, input int n, input logic [7:0] exp [16], input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(SEL_W, ack);
        send_byte({1'b0, a[14:8]}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(SEL_R, ack); check(ack, "R9 read select ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(b == exp[i], req, b, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);
    endtask

    task automatic t_mismatch();
        bit ack;
        bus_start(); send_byte(8'hA2, ack); check(!ack, "R3 wrong strap", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R3 silent until start", ack, 0);
        bus_stop();
        bus_start(); send_byte(8'hB4, ack); check(!ack, "R3 wrong code", ack, 0);
        bus_stop();
    endtask

    task automatic t_stop_no_data();
        bit ack;
        bus_start(); send_byte(SEL_W, ack); send_byte(8'h00, ack); bus_stop();
        bus_start(); send_byte(SEL_W, ack);
        check(ack, "R1 standby after stop w/o data", ack, 1);
        bus_stop();
    endtask

    task automatic t_byte_write();
        int polls;
        logic [7:0] e [16];
        write_burst(15'h0005, 1, 8'h3C);
        wait_ready(polls);
        check(polls >= 1, "R6 busy nacks poll", polls, 1);
        e[0] = 8'h3C;
        rand_read_check(15'h0005, 1, e, "R9 random read byte");
    endtask

    task automatic t_page_wrap();
        int polls;
        logic [7:0] e [16];
        bit ack;
        logic [7:0] b;
        write_burst(15'h000E, 10, 8'h50);
        wait_ready(polls);
        for (int i = 0; i < 8; i++) e[i] = 8'h52 + 8'(i);
        rand_read_check(15'h0008, 8, e, "R5 page wrap content / R8 sequential");
        e[0] = 8'h52;
        rand_read_check(15'h0008, 1, e, "R8 single read");
        bus_start(); send_byte(SEL_R, ack);
        recv_byte(1'b0, b);
        check(b == 8'h53, "R8 current address read", b, 8'h53);
        bus_stop();
        check(unstable == 0, "R10 SDA steady while SCL high", unstable, 0);
    endtask

    task automatic t_protect();
        int polls;
        logic [7:0] e [16];
        wp = 1'b1;
        write_burst(15'h0005, 1, 8'hFF);
        wait_ready(polls);
        check(polls >= 1, "R7 busy runs under protect", polls, 1);
        wp = 1'b0;
        e[0] = 8'h3C;
        rand_read_check(15'h0005, 1, e, "R7 array unchanged");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_mismatch();
        t_stop_no_data();
        t_byte_write();
        t_page_wrap();
        t_protect();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule